// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Modulator

This block drives the four switches of a full bridge. One leg, the master, runs as a fixed complementary square wave. It flips state once per modulation frame. The other leg, the slave, is a complementary pair that follows the master with a programmable lag. The lag sets how long the diagonal switches conduct together, and so how much energy each half-cycle transfers.

In the internal mode, an 8-bit free-running counter sets the frame. When it wraps it issues a frame strobe. A comparison of the counter against a shadowed compare value gives the modulation level, and the falling edge of that level marks the slave transition. In the bypass mode, both the frame strobe and the modulation level come from input pins, so that an outside source, such as an analog ramp comparator, can set the phase.

The raw leg states are brought out for external delay circuits. Each gated output is its raw state ANDed with a global enable and a per-channel gate input. An outside dead-time stage uses the gate inputs to hold back each rising edge.

The slave leg is a two-state machine (LEG_POS / LEG_NEG), and so is the master leg. Each clock, the event pair is classified as EV_IDLE, EV_PHASE, EV_FRAME or EV_BOTH:
- On EV_FRAME and EV_BOTH, the master moves to the opposite state.
- On EV_PHASE, EV_FRAME and EV_BOTH, the slave takes the state the master held in that cycle.
- On EV_IDLE, both legs hold.

Top module: `psfb_modulator`

## Requirements
- R1: While reset is held, the raw outputs are master-high 0, master-low 1, slave-high 0 and slave-low 1, and the counter is at zero.
- R2: In internal mode, the master-high output changes state exactly every 256 clocks. The frame strobe fires in the cycle the counter holds 255.
- R3: At every clock, each raw pair is complementary: master-low is the inverse of master-high, and slave-low is the inverse of slave-high.
- R4: In internal mode, the modulation level is high while count <= compare. In the cycle after a falling edge is seen, the slave-high output equals the master-high output. Over any 256 consecutive clocks in steady state, master-high and slave-high differ for min(compare+2, 256) clocks.
- R5: A frame strobe also copies the pre-toggle master state into the slave. As a result, compare values 254 and 255 give a full half-period of disagreement (256 clocks), including the case where the modulation level never falls.
- R6: The compare input is captured only at the frame strobe. A change made during a frame has no effect on that frame's slave transition and takes effect in the next frame.
- R7: With bypass high, the internal timer has no effect on the legs. A one-clock high on ext_sof toggles the master on the next clock. A high-to-low step on ext_phase copies the master into the slave on the next clock.
- R8: With out_en low, all four gated outputs are low at once, while the raw outputs keep running.
- R9: Gated output i equals raw output i AND out_en AND gate_in[i]. Bit 0 is master-high, bit 1 is master-low, bit 2 is slave-high and bit 3 is slave-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_val | input | 8 | Phase compare value, captured at each frame strobe |
| out_en | input | 1 | Global output enable, acts without a clock |
| bypass | input | 1 | 1: take frame and phase events from the pins |
| ext_sof | input | 1 | External frame strobe, one clock wide |
| ext_phase | input | 1 | External modulation level; its falling edge is the phase event |
| gate_in | input | 4 | Per-channel delay gates {slv_lo, slv_hi, mst_lo, mst_hi} |
| raw_mst_hi | output | 1 | Ungated master high-side state |
| raw_mst_lo | output | 1 | Ungated master low-side state |
| raw_slv_hi | output | 1 | Ungated slave high-side state |
| raw_slv_lo | output | 1 | Ungated slave low-side state |
| drv_mst_hi | output | 1 | Gated master high-side drive |
| drv_mst_lo | output | 1 | Gated master low-side drive |
| drv_slv_hi | output | 1 | Gated slave high-side drive |
| drv_slv_lo | output | 1 | Gated slave low-side drive |

## Verification
The checker assumes that every input is synchronous to clk, that ext_sof is a single-clock strobe, and that neither the frame event nor the phase event occurs while reset is asserted. It also assumes that the bypass select changes only between frames that it re-learns, so the frame-spacing count is restarted whenever bypass is high. The bench drives all inputs on the falling clock edge and raises external events only after reset is released. When it leaves bypass mode, it waits several frames before measuring phase, so every window it scores lies in a settled frame.

// File: rtl/psfb_pkg.sv
`timescale 1ns/1ps
package psfb_pkg;

    // Leg state: positive means the high-side switch of that leg is on.
    typedef enum logic {
        LEG_NEG = 1'b0,
        LEG_POS = 1'b1
    } leg_state_t;

    // Per-cycle event classification, encoded as {frame, phase}.
    typedef enum logic [1:0] {
        EV_IDLE  = 2'b00,
        EV_PHASE = 2'b01,
        EV_FRAME = 2'b10,
        EV_BOTH  = 2'b11
    } leg_event_t;

    // Gate/output channel order shared by the ports and the gating stage.
    localparam int unsigned CH_MST_HI = 0;
    localparam int unsigned CH_MST_LO = 1;
    localparam int unsigned CH_SLV_HI = 2;
    localparam int unsigned CH_SLV_LO = 3;
    localparam int unsigned NUM_CH    = 4;

endpackage

// File: rtl/psfb_timer.sv
`timescale 1ns/1ps
// Free-running frame counter with a shadowed compare value.
module psfb_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             tc,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;

    assign tc  = (cnt_q == CNT_LAST);
    assign pwm = (cnt_q <= cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            // New compare value lands only at the frame boundary.
            if (tc) begin
                cmp_q <= cmp_in;
            end
        end
    end
endmodule

// File: rtl/psfb_event_sel.sv
`timescale 1ns/1ps
// Chooses the event source and finds the modulation falling edge.
module psfb_event_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic int_tc,
    input  logic int_pwm,
    input  logic ext_sof,
    input  logic ext_phase,
    output logic frame_evt,
    output logic phase_fall
);
    logic mod_lvl;
    logic mod_q;

    assign frame_evt  = bypass ? ext_sof   : int_tc;
    assign mod_lvl    = bypass ? ext_phase : int_pwm;
    assign phase_fall = mod_q & ~mod_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= 1'b0;
        end else begin
            mod_q <= mod_lvl;
        end
    end
endmodule

// File: rtl/psfb_leg_ctrl.sv
`timescale 1ns/1ps
// Master and slave leg state machines.
module psfb_leg_ctrl
    import psfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_evt,
    input  logic phase_fall,
    output logic master_hi,
    output logic slave_hi
);
    leg_state_t mst_q, mst_n;
    leg_state_t slv_q, slv_n;
    leg_event_t ev;

    assign ev = leg_event_t'({frame_evt, phase_fall});

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q <= LEG_NEG;
            slv_q <= LEG_NEG;
        end else begin
            mst_q <= mst_n;
            slv_q <= slv_n;
        end
    end

    // Next-state selection per event class.
    always_comb begin
        mst_n = mst_q;
        slv_n = slv_q;
        unique case (ev)
            EV_IDLE: begin
                mst_n = mst_q;
                slv_n = slv_q;
            end
            EV_PHASE: begin
                slv_n = mst_q;
            end
            EV_FRAME, EV_BOTH: begin
                mst_n = (mst_q == LEG_POS) ? LEG_NEG : LEG_POS;
                slv_n = mst_q;
            end
            default: begin
                mst_n = mst_q;
                slv_n = slv_q;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        master_hi = (mst_q == LEG_POS);
        slave_hi  = (slv_q == LEG_POS);
    end
endmodule

// File: rtl/psfb_gate.sv
`timescale 1ns/1ps
// Three-input AND per channel: raw state, global enable, delay gate.
module psfb_gate #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] raw,
    input  logic         en,
    input  logic [N-1:0] gate_in,
    output logic [N-1:0] drv
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        assign drv[g] = raw[g] & en & gate_in[g];
    end
endmodule

// File: rtl/psfb_modulator.sv
`timescale 1ns/1ps
module psfb_modulator
    import psfb_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             out_en,
    input  logic             bypass,
    input  logic             ext_sof,
    input  logic             ext_phase,
    input  logic [3:0]       gate_in,
    output logic             raw_mst_hi,
    output logic             raw_mst_lo,
    output logic             raw_slv_hi,
    output logic             raw_slv_lo,
    output logic             drv_mst_hi,
    output logic             drv_mst_lo,
    output logic             drv_slv_hi,
    output logic             drv_slv_lo
);
    logic              int_tc;
    logic              int_pwm;
    logic              frame_evt;
    logic              phase_fall;
    logic              master_hi;
    logic              slave_hi;
    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] drv_vec;

    psfb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_in (cmp_val),
        .tc     (int_tc),
        .pwm    (int_pwm)
    );

    psfb_event_sel u_evsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .int_tc     (int_tc),
        .int_pwm    (int_pwm),
        .ext_sof    (ext_sof),
        .ext_phase  (ext_phase),
        .frame_evt  (frame_evt),
        .phase_fall (phase_fall)
    );

    psfb_leg_ctrl u_legs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_evt  (frame_evt),
        .phase_fall (phase_fall),
        .master_hi  (master_hi),
        .slave_hi   (slave_hi)
    );

    always_comb begin
        raw_vec[CH_MST_HI] = master_hi;
        raw_vec[CH_MST_LO] = ~master_hi;
        raw_vec[CH_SLV_HI] = slave_hi;
        raw_vec[CH_SLV_LO] = ~slave_hi;
    end

    psfb_gate #(.N(NUM_CH)) u_gate (
        .raw     (raw_vec),
        .en      (out_en),
        .gate_in (gate_in),
        .drv     (drv_vec)
    );

    assign raw_mst_hi = raw_vec[CH_MST_HI];
    assign raw_mst_lo = raw_vec[CH_MST_LO];
    assign raw_slv_hi = raw_vec[CH_SLV_HI];
    assign raw_slv_lo = raw_vec[CH_SLV_LO];
    assign drv_mst_hi = drv_vec[CH_MST_HI];
    assign drv_mst_lo = drv_vec[CH_MST_LO];
    assign drv_slv_hi = drv_vec[CH_SLV_HI];
    assign drv_slv_lo = drv_vec[CH_SLV_LO];
endmodule

// File: rtl/psfb_modulator_chk.sv
`timescale 1ns/1ps
module psfb_modulator_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bypass,
    input logic       out_en,
    input logic       frame_evt,
    input logic       phase_fall,
    input logic       raw_mst_hi,
    input logic       raw_slv_hi,
    input logic [3:0] drv_all
);
    localparam int unsigned PERIOD = 1 << CNT_W;

    logic [CNT_W:0] gap_q;
    logic           armed_q;

    // Counts clocks since the last frame event; restarts whenever bypass is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b1;
        end else if (bypass) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (frame_evt) begin
            gap_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            gap_q   <= gap_q + 1'b1;
        end
    end

    assert_frame_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && armed_q && frame_evt) |-> (gap_q == (CNT_W+1)'(PERIOD - 1)));

    assert_master_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> (raw_mst_hi != $past(raw_mst_hi)));

    assert_master_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_evt |=> $stable(raw_mst_hi));

    assert_slave_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt || phase_fall) |=> (raw_slv_hi == $past(raw_mst_hi)));

    assert_slave_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_evt || phase_fall) |=> $stable(raw_slv_hi));

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (drv_all == 4'b0000));
endmodule

bind psfb_modulator psfb_modulator_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass     (bypass),
    .out_en     (out_en),
    .frame_evt  (frame_evt),
    .phase_fall (phase_fall),
    .raw_mst_hi (raw_mst_hi),
    .raw_slv_hi (raw_slv_hi),
    .drv_all    ({drv_slv_lo, drv_slv_hi, drv_mst_lo, drv_mst_hi})
);

// File: tb/tb_psfb_modulator.sv
`timescale 1ns/1ps
module tb_psfb_modulator;
    localparam int PERIOD = 256;
    localparam int NVEC   = 12;
    // {compare value, expected disagreement clocks per 256-clock window}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'd0,   9'd2},   {8'd1,   9'd3},   {8'd2,   9'd4},
        {8'd17,  9'd19},  {8'd64,  9'd66},  {8'd100, 9'd102},
        {8'd127, 9'd129}, {8'd128, 9'd130}, {8'd200, 9'd202},
        {8'd253, 9'd255}, {8'd254, 9'd256}, {8'd255, 9'd256}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmp_val = 8'd0;
    logic       out_en = 1'b1;
    logic       bypass = 1'b0;
    logic       ext_sof = 1'b0;
    logic       ext_phase = 1'b0;
    logic [3:0] gate_in = 4'hF;
    logic raw_mst_hi, raw_mst_lo, raw_slv_hi, raw_slv_lo;
    logic drv_mst_hi, drv_mst_lo, drv_slv_hi, drv_slv_lo;
    logic [3:0] raw, drv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign raw = {raw_slv_lo, raw_slv_hi, raw_mst_lo, raw_mst_hi};
    assign drv = {drv_slv_lo, drv_slv_hi, drv_mst_lo, drv_mst_hi};

    always #2.5 clk = ~clk;

    psfb_modulator dut (
        .clk(clk), .rst_n(rst_n), .cmp_val(cmp_val), .out_en(out_en),
        .bypass(bypass), .ext_sof(ext_sof), .ext_phase(ext_phase), .gate_in(gate_in),
        .raw_mst_hi(raw_mst_hi), .raw_mst_lo(raw_mst_lo),
        .raw_slv_hi(raw_slv_hi), .raw_slv_lo(raw_slv_lo),
        .drv_mst_hi(drv_mst_hi), .drv_mst_lo(drv_mst_lo),
        .drv_slv_hi(drv_slv_hi), .drv_slv_lo(drv_slv_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_master_edge();
        logic prev;
        prev = raw_mst_hi;
        @(negedge clk);
        while (raw_mst_hi == prev) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic old_m;
        int   n;
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        check(raw == 4'b1010, "R1", raw, 4'b1010);
        check(drv == 4'b1010, "R1", drv, 4'b1010);
        rst_n = 1'b1;

        // R4, R5, R3: phase lag sweep from the vector table
        for (int i = 0; i < NVEC; i++) begin
            int dis, bad, expd;
            cmp_val = VEC[i][16:9];
            expd    = int'(VEC[i][8:0]);
            repeat (3 * PERIOD) @(negedge clk);
            dis = 0;
            bad = 0;
            repeat (PERIOD) begin
                @(negedge clk);
                if (raw_mst_hi != raw_slv_hi) dis++;
                if (raw_mst_hi == raw_mst_lo || raw_slv_hi == raw_slv_lo) bad++;
            end
            check(dis == expd, (expd == PERIOD) ? "R5" : "R4", dis, expd);
            check(bad == 0, "R3", bad, 0);
        end

        // R2: master half-period
        wait_master_edge();
        n = 0;
        old_m = raw_mst_hi;
        do begin
            @(negedge clk);
            n++;
        end while (raw_mst_hi == old_m && n < 1000);
        check(n == PERIOD, "R2", n, PERIOD);

        // R6: compare change mid-frame waits for the frame boundary
        cmp_val = 8'd100;
        repeat (3 * PERIOD) @(negedge clk);
        wait_master_edge();
        cmp_val = 8'd10;
        repeat (50) @(negedge clk);
        check(raw_mst_hi != raw_slv_hi, "R6", raw_slv_hi, !raw_mst_hi);
        wait_master_edge();
        repeat (50) @(negedge clk);
        check(raw_mst_hi == raw_slv_hi, "R6", raw_slv_hi, raw_mst_hi);

        // R7: bypass mode
        bypass    = 1'b1;
        ext_phase = 1'b0;
        repeat (5) @(negedge clk);
        old_m = raw_mst_hi;
        begin
            logic old_s;
            old_s = raw_slv_hi;
            repeat (600) @(negedge clk);
            check(raw_mst_hi == old_m, "R7", raw_mst_hi, old_m);
            check(raw_slv_hi == old_s, "R7", raw_slv_hi, old_s);
        end
        ext_sof = 1'b1;
        @(negedge clk);
        ext_sof = 1'b0;
        check(raw_mst_hi == !old_m, "R7", raw_mst_hi, !old_m);
        check(raw_slv_hi == old_m, "R7", raw_slv_hi, old_m);
        ext_phase = 1'b1;
        repeat (3) @(negedge clk);
        check(raw_slv_hi == old_m, "R7", raw_slv_hi, old_m);
        ext_phase = 1'b0;
        @(negedge clk);
        check(raw_slv_hi == !old_m, "R7", raw_slv_hi, !old_m);

        // R8: enable low blocks all drives
        bypass  = 1'b0;
        gate_in = 4'hF;
        out_en  = 1'b0;
        @(negedge clk);
        check(drv == 4'b0000, "R8", drv, 0);
        check(raw_mst_hi != raw_mst_lo, "R8", raw_mst_lo, !raw_mst_hi);

        // R9: per-channel gating
        out_en  = 1'b1;
        gate_in = 4'b0101;
        for (int k = 0; k < 4; k++) begin
            repeat (130) @(negedge clk);
            check(drv == (raw & 4'b0101), "R9", drv, raw & 4'b0101);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule